// File: doc/BRIEF.md
# Masked Packed-Lane XOR Unit

This block is one vector execution slice. It XORs two wide source vectors lane by lane, with 32-bit lanes. It serves three encoding classes. The legacy class computes the low quarter of the vector and passes every bit above that quarter through from the old destination. The plain class computes a selectable active length and clears everything above it. The masked class adds per-lane write enables, a choice between merging and zeroing for disabled lanes, and a broadcast of one 32-bit scalar taken from source B.

A caller presents both sources, the old destination value, a lane mask, a length code and the mode flags, and pulses `in_vld`. The result, a length-error flag and `res_vld` appear on the registered outputs one clock later. The operation is purely bitwise. Floating-point encodings such as NaN or denormal values get no special handling, and no exception flags are raised.

Top module: `vxl_xor_slice`

## Requirements
- R1: For every computed lane j, res_o[32j+31:32j] equals src_a_i[32j+31:32j] XOR the source-B operand of that lane.
- R2: len_sel_i selects the active lane count in the plain and masked classes: 2'b00 gives 4 lanes, 2'b01 gives 8 and 2'b10 gives 16. Code 2'b11 acts as 16 lanes and drives len_err_o high together with the result. In every class, len_err_o is high exactly when the sampled code was 2'b11.
- R3: In the masked class (cls_i = 2'b10), an active lane is computed when mask_en_i is 0 or when lane_mask_i[j] is 1. Mask bits at or above the active lane count have no effect.
- R4: In the masked class with mask_en_i = 1, an active lane j whose lane_mask_i[j] is 0 takes old_i's lane when zero_mode_i is 0, and takes zero when zero_mode_i is 1.
- R5: In the masked class, when bcast_i and b_mem_i are both 1, src_b_i[31:0] is the source-B operand of every active lane. When either flag is 0, each lane uses its own slice of src_b_i.
- R6: In the plain and masked classes, every result bit from the active length up to bit 511 is zero.
- R7: In the legacy class (cls_i = 2'b00), lanes 0 to 3 are XORed and bits 511:128 equal old_i[511:128]. len_sel_i, lane_mask_i, mask_en_i, zero_mode_i, bcast_i and b_mem_i do not change res_o.
- R8: In the plain class (cls_i = 2'b01), and for class code 2'b11, which behaves the same, all active lanes are computed per lane. lane_mask_i, mask_en_i, zero_mode_i, bcast_i and b_mem_i do not change res_o.
- R9: res_o, len_err_o and res_vld_o update on the clock edge that samples in_vld_i = 1. res_vld_o is low in the cycle after any cycle without in_vld_i, and res_o holds its value then.
- R10: A synchronous reset (rst_i high at a clock edge) clears res_vld_o, len_err_o and res_o, even if in_vld_i is high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_vld_i | input | 1 | Sample strobe for all operand and control inputs |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector; bits 31:0 double as the broadcast scalar |
| old_i | input | 512 | Old destination value, used for merged lanes and legacy upper bits |
| lane_mask_i | input | 16 | Per-lane write enables, bit j for lane j |
| len_sel_i | input | 2 | Active length code |
| cls_i | input | 2 | Encoding class: 00 legacy, 01 plain, 10 masked, 11 as plain |
| mask_en_i | input | 1 | Masked class: 1 applies lane_mask_i |
| zero_mode_i | input | 1 | Masked class: 1 zeroes disabled lanes, 0 merges them |
| bcast_i | input | 1 | Masked class: broadcast request |
| b_mem_i | input | 1 | Source B is flagged as a memory operand |
| res_o | output | 512 | Registered result vector |
| res_vld_o | output | 1 | Result valid, one clock after in_vld_i |
| len_err_o | output | 1 | Sampled length code was the reserved value |

## Verification
Broadcast and write masking can act on the same lane in the same cycle. A broadcast lane can therefore be merged, zeroed or computed depending on its mask bit. The bench provokes this with a masked-class vector that sets broadcast, memory flag, merge mode and a sparse mask together, plus one that adds stray mask bits above a short active length. Each result is compared word for word against a model built from the requirements, in which the mask decision is taken before the operand choice, so a lane is never partly broadcast.

// File: rtl/vxl_pkg.sv
package vxl_pkg;

   typedef enum logic [1:0] {
      CLS_LEGACY = 2'b00,
      CLS_PLAIN  = 2'b01,
      CLS_MASKED = 2'b10,
      CLS_RSVD   = 2'b11
   } vxl_cls_e;

   localparam logic [1:0] LEN_Q    = 2'b00;
   localparam logic [1:0] LEN_H    = 2'b01;
   localparam logic [1:0] LEN_F    = 2'b10;
   localparam logic [1:0] LEN_BAD  = 2'b11;

endpackage

// File: rtl/vxl_lane_ctl.sv
module vxl_lane_ctl
   import vxl_pkg::*;
#(
   parameter int NUM_LANES = 16
) (
   input  vxl_cls_e               cls,
   input  logic [1:0]             len_sel,
   input  logic [NUM_LANES-1:0]   lane_mask,
   input  logic                   mask_en,
   input  logic                   zero_mode,
   input  logic                   bcast,
   input  logic                   b_mem,
   output logic [NUM_LANES-1:0]   sel_xor,
   output logic [NUM_LANES-1:0]   sel_old,
   output logic                   use_bc,
   output logic                   len_bad
);
   localparam int QTR_LANES  = NUM_LANES / 4;
   localparam int HALF_LANES = NUM_LANES / 2;

   if (NUM_LANES < 4 || (NUM_LANES % 4) != 0) begin : g_bad_lanes
      $error("vxl_lane_ctl: NUM_LANES must be a multiple of 4");
   end

   logic is_leg, is_msk;
   assign is_leg  = (cls == CLS_LEGACY);
   assign is_msk  = (cls == CLS_MASKED);
   assign len_bad = (len_sel == LEN_BAD);
   assign use_bc  = is_msk && bcast && b_mem;

   for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
      logic in_q, in_h, act, on;
      assign in_q = (j < QTR_LANES);
      assign in_h = (j < HALF_LANES);
      assign act  = is_leg ? in_q :
                    (len_sel == LEN_Q) ? in_q :
                    (len_sel == LEN_H) ? in_h : 1'b1;
      assign on   = !is_msk || !mask_en || lane_mask[j];
      assign sel_xor[j] = act && on;
      assign sel_old[j] = is_leg ? !act : (act && !on && !zero_mode);
   end

endmodule

// File: rtl/vxl_lane.sv
module vxl_lane #(
   parameter int LANE_W   = 32,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic [LANE_W-1:0] b_scalar,
   input  logic [LANE_W-1:0] old,
   input  logic              sel_xor,
   input  logic              sel_old,
   input  logic              use_bc,
   output logic [LANE_W-1:0] y
);
   logic [LANE_W-1:0] opnd;

   if (BCAST_EN) begin : g_bc
      assign opnd = use_bc ? b_scalar : b;
   end else begin : g_nobc
      logic unused_bc;
      assign unused_bc = use_bc ^ (^b_scalar);
      assign opnd = b;
   end

   always_comb begin
      if (sel_xor)      y = a ^ opnd;
      else if (sel_old) y = old;
      else              y = '0;
   end

endmodule

// File: rtl/vxl_xor_slice.sv
module vxl_xor_slice
   import vxl_pkg::*;
#(
   parameter int LANE_W    = 32,
   parameter int NUM_LANES = 16,
   parameter bit BCAST_EN  = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic                          in_vld_i,
   input  logic [LANE_W*NUM_LANES-1:0]   src_a_i,
   input  logic [LANE_W*NUM_LANES-1:0]   src_b_i,
   input  logic [LANE_W*NUM_LANES-1:0]   old_i,
   input  logic [NUM_LANES-1:0]          lane_mask_i,
   input  logic [1:0]                    len_sel_i,
   input  logic [1:0]                    cls_i,
   input  logic                          mask_en_i,
   input  logic                          zero_mode_i,
   input  logic                          bcast_i,
   input  logic                          b_mem_i,
   output logic [LANE_W*NUM_LANES-1:0]   res_o,
   output logic                          res_vld_o,
   output logic                          len_err_o
);
   localparam int VEC_W = LANE_W * NUM_LANES;
   localparam int QTR_W = VEC_W / 4;

   if (LANE_W < 1) begin : g_bad_w
      $error("vxl_xor_slice: LANE_W must be positive");
   end

   vxl_cls_e               cls;
   logic [NUM_LANES-1:0]   sel_xor, sel_old;
   logic                   use_bc, len_bad;
   logic [VEC_W-1:0]       nxt;

   assign cls = vxl_cls_e'(cls_i);

   vxl_lane_ctl #(.NUM_LANES(NUM_LANES)) u_ctl (
      .cls       (cls),
      .len_sel   (len_sel_i),
      .lane_mask (lane_mask_i),
      .mask_en   (mask_en_i),
      .zero_mode (zero_mode_i),
      .bcast     (bcast_i),
      .b_mem     (b_mem_i),
      .sel_xor   (sel_xor),
      .sel_old   (sel_old),
      .use_bc    (use_bc),
      .len_bad   (len_bad)
   );

   for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
      vxl_lane #(.LANE_W(LANE_W), .BCAST_EN(BCAST_EN)) u_lane (
         .a        (src_a_i[j*LANE_W +: LANE_W]),
         .b        (src_b_i[j*LANE_W +: LANE_W]),
         .b_scalar (src_b_i[LANE_W-1:0]),
         .old      (old_i[j*LANE_W +: LANE_W]),
         .sel_xor  (sel_xor[j]),
         .sel_old  (sel_old[j]),
         .use_bc   (use_bc),
         .y        (nxt[j*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         res_vld_o <= 1'b0;
         len_err_o <= 1'b0;
         res_o     <= '0;
      end else begin
         res_vld_o <= in_vld_i;
         if (in_vld_i) begin
            res_o     <= nxt;
            len_err_o <= len_bad;
         end
      end
   end

   AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      in_vld_i |=> res_vld_o); // R9
   AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !in_vld_i |=> !res_vld_o); // R9
   AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !in_vld_i |=> $stable(res_o)); // R9
   AST_LEN_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
      in_vld_i |=> (len_err_o == ($past(len_sel_i) == LEN_BAD))); // R2
   AST_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_vld_i && cls_i != CLS_LEGACY && len_sel_i == LEN_Q)
      |=> (res_o[VEC_W-1:QTR_W] == '0)); // R6
   AST_LEGACY_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_vld_i && cls_i == CLS_LEGACY)
      |=> (res_o[VEC_W-1:QTR_W] == $past(old_i[VEC_W-1:QTR_W]))); // R7
   AST_ZERO_LANE0: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_vld_i && cls_i == CLS_MASKED && mask_en_i && zero_mode_i && !lane_mask_i[0])
      |=> (res_o[LANE_W-1:0] == '0)); // R4

endmodule

// File: tb/sim_vxl_xor_slice.sv
`timescale 1ns/1ps
module sim_vxl_xor_slice;

   typedef struct packed {
      logic [31:0] sa;
      logic [31:0] sb;
      logic [31:0] so;
      logic [15:0] m;
      logic [1:0]  len;
      logic [1:0]  cls;
      logic        men;
      logic        zm;
      logic        bc;
      logic        mem;
   } vec_t;

   // fields: sa, sb, so, mask, len, cls, mask_en, zero_mode, bcast, b_mem
   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{32'h0123_4567, 32'h89AB_CDEF, 32'h5A5A_5A5A, 16'hFFFF, 2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1}, // R1 R6 R8
      '{32'hDEAD_BEEF, 32'h1357_9BDF, 32'hA5A5_0F0F, 16'h0000, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 R8
      '{32'hFFFF_0000, 32'h0F0F_F0F0, 32'h1111_2222, 16'h0000, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 R2
      '{32'h7FC0_0001, 32'h8000_0000, 32'h3333_4444, 16'hA5C3, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 merge
      '{32'h0080_0000, 32'h4242_4242, 32'h9999_AAAA, 16'hFF0F, 2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 R4 R6
      '{32'hCAFE_F00D, 32'h0000_00FF, 32'h7777_8888, 16'h0000, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 R3
      '{32'hCAFE_F00D, 32'h0000_00FF, 32'h7777_8888, 16'hFFFF, 2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 no mem
      '{32'h1234_0000, 32'h0000_4321, 32'hEEEE_DDDD, 16'h0005, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 R4 same cycle
      '{32'h0BAD_CAFE, 32'hFACE_B00C, 32'h2468_ACE0, 16'h0000, 2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
      '{32'h0BAD_CAFE, 32'hFACE_B00C, 32'h1357_0246, 16'h0001, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 R2
      '{32'h5555_AAAA, 32'h3C3C_C3C3, 32'h0000_FFFF, 16'h0000, 2'd3, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 code 11
      '{32'h8765_4321, 32'h1122_3344, 32'hBBBB_CCCC, 16'h0000, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1}  // R8 class 11
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_vld = 1'b0;
   logic [511:0]  src_a = '0, src_b = '0, old = '0;
   logic [15:0]   lane_mask = '0;
   logic [1:0]    len_sel = '0, cls = '0;
   logic          mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0, b_mem = 1'b0;
   logic [511:0]  res;
   logic          res_vld, len_err;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   vxl_xor_slice u0 (
      .clk_i(clk), .rst_i(rst), .in_vld_i(in_vld),
      .src_a_i(src_a), .src_b_i(src_b), .old_i(old),
      .lane_mask_i(lane_mask), .len_sel_i(len_sel), .cls_i(cls),
      .mask_en_i(mask_en), .zero_mode_i(zero_mode), .bcast_i(bcast), .b_mem_i(b_mem),
      .res_o(res), .res_vld_o(res_vld), .len_err_o(len_err)
   );

   function automatic logic [511:0] spread(input logic [31:0] s);
      logic [511:0] r;
      for (int j = 0; j < 16; j++) r[j*32 +: 32] = s + 32'(j) * 32'h9E37_79B9;
      return r;
   endfunction

   function automatic logic [511:0] model(input vec_t v);
      logic [511:0] a, b, o, r;
      logic [31:0]  bl;
      int n;
      a = spread(v.sa); b = spread(v.sb); o = spread(v.so);
      n = (v.cls == 2'd0) ? 4 : (v.len == 2'd0) ? 4 : (v.len == 2'd1) ? 8 : 16;
      for (int j = 0; j < 16; j++) begin
         if (j >= n) r[j*32 +: 32] = (v.cls == 2'd0) ? o[j*32 +: 32] : 32'h0;
         else begin
            bl = (v.cls == 2'd2 && v.bc && v.mem) ? b[31:0] : b[j*32 +: 32];
            if (v.cls == 2'd2 && v.men && !v.m[j])
               r[j*32 +: 32] = v.zm ? 32'h0 : o[j*32 +: 32];
            else
               r[j*32 +: 32] = a[j*32 +: 32] ^ bl;
         end
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      src_a = spread(v.sa); src_b = spread(v.sb); old = spread(v.so);
      lane_mask = v.m; len_sel = v.len; cls = v.cls;
      mask_en = v.men; zero_mode = v.zm; bcast = v.bc; b_mem = v.mem;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      logic [511:0] e, keep;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10 reset state
      chk(res_vld == 1'b0 && len_err == 1'b0, "R10 reset flags", {510'h0, res_vld, len_err}, 512'h0);
      chk(res == '0, "R10 reset result", res, '0);

      // table walk: R1..R8 and R9 timing
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(TBL[k]); in_vld = 1'b1;
         @(negedge clk);
         in_vld = 1'b0;
         e = model(TBL[k]);
         chk(res == e, $sformatf("R1-vector %0d result (R3 R4 R5 R6 R7 R8)", k), res, e);
         chk(len_err == (TBL[k].len == 2'd3), "R2 len_err", {511'h0, len_err}, {511'h0, TBL[k].len == 2'd3});
         chk(res_vld == 1'b1, "R9 valid after sample", {511'h0, res_vld}, 512'h1);
      end

      // R9 idle: inputs change without strobe, result holds, valid low
      keep = res;
      drive(TBL[2]);
      @(negedge clk);
      chk(res_vld == 1'b0, "R9 valid low when idle", {511'h0, res_vld}, 512'h0);
      chk(res == keep, "R9 result holds when idle", res, keep);

      // R9 back-to-back samples
      drive(TBL[3]); in_vld = 1'b1;
      @(negedge clk);
      e = model(TBL[3]);
      chk(res == e && res_vld, "R9 back-to-back first", res, e);
      drive(TBL[7]);
      @(negedge clk);
      in_vld = 1'b0;
      e = model(TBL[7]);
      chk(res == e && res_vld, "R9 back-to-back second (R5 with R4)", res, e);

      // R10 reset wins over strobe
      drive(TBL[10]); in_vld = 1'b1; rst = 1'b1;
      @(negedge clk);
      in_vld = 1'b0; rst = 1'b0;
      chk(res_vld == 1'b0 && len_err == 1'b0, "R10 reset beats strobe flags", {510'h0, res_vld, len_err}, 512'h0);
      chk(res == '0, "R10 reset beats strobe result", res, '0);

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule